// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio N = 16·M + A, as the feedback path of a frequency synthesiser. A dual-modulus prescaler, built in logic, counts either 17 or 16 input clocks per period. A 13-bit main counter counts prescaler periods. A 4-bit swallow counter picks how many of those periods use the longer modulus. Each time a full N-count completes, the block emits a one-clock pulse for the phase comparator. It also toggles a half-rate output that a test port can observe.

Software writes a 17-bit ratio word with a one-clock load strobe. The word is checked on arrival. An acceptable word is parked until the current division cycle finishes and is then applied, so the output period never takes a value between the old ratio and the new one. A word that is too small is refused and raises an error flag. The divider then keeps running at the ratio it already had. Out of reset the divider runs at ratio 240.

Top module: `swallowDivider`

## Requirements
- R1: While reset is asserted, divPulse, divHalf and ratioErr are 0. After reset is released, the divider runs at ratio 240: the first divPulse comes on the 240th rising clock edge after release, and the following ones come every 240 edges.
- R2: The ratio word is split with M = ratioWord[16:4] and A = ratioWord[3:0]. Once applied, the distance between consecutive divPulse assertions is exactly 16·M + A input clocks.
- R3: divPulse is high for exactly one clock per division cycle. It is asserted on the edge that completes the N-count.
- R4: An accepted ratio never changes a cycle that is already in progress. That cycle ends with the previous ratio, and the new ratio governs the cycle that starts at that boundary.
- R5: A word whose value is below 240, or whose A field exceeds its M field, is refused. ratioErr goes to 1 on the edge that samples the load and stays there until the next accepted load, which clears it. A refused word leaves the division period unchanged.
- R6: divHalf toggles on every edge where divPulse is asserted and holds otherwise, giving a square wave of period 2N.
- R7: If several loads are accepted before one boundary, the last accepted word is applied. A load sampled on the boundary edge itself is applied at the following boundary.
- R8: The largest ratio, 131071 (all word bits 1), divides correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioWord | input | 17 | Ratio word, M in bits 16:4, A in bits 3:0 |
| loadStrobe | input | 1 | One-clock strobe that samples ratioWord |
| divPulse | output | 1 | One-clock pulse at the end of each N-count |
| divHalf | output | 1 | Divided output halved, toggles on each divPulse |
| ratioErr | output | 1 | Last load was refused |

## Verification
The internal state of this block is visible at the ports only through the timing of divPulse. A wrong prescaler modulus, a skipped swallow decrement or a reload from the wrong register therefore shows up as a pulse spacing that is off by one or more clocks from 16·M + A, at the first boundary after the fault. A ratio applied too early or too late shows as the period right after a load matching the new ratio instead of the old one, or the reverse. For that reason every load is followed by measuring both the cycle that was in progress and the next cycle. A divHalf that misses a toggle is caught at the next pulse.

// File: rtl/swallowDivPkg.sv
package swallowDivPkg;

  // Strobes issued by the prescaler control to the counter datapath.
  typedef struct packed {
    logic presWrap;     // prescaler finished one 16- or 17-clock period
    logic swallowStep;  // that period used the long modulus, count it off
    logic cycleEnd;     // last prescaler period of the N-count has finished
  } divStrobes_t;

endpackage

// File: rtl/swallowDivLoadCheck.sv
module swallowDivLoadCheck #(
  parameter int MAIN_W    = 13,
  parameter int SWAL_W    = 4,
  parameter int MIN_RATIO = 240,
  localparam int RATIO_W  = MAIN_W + SWAL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioWord,
  input  logic               loadStrobe,
  output logic               loadAccept,
  output logic               ratioErr
);

  localparam logic [RATIO_W-1:0] MIN_WORD = RATIO_W'(MIN_RATIO);

  logic [MAIN_W-1:0] mainField;
  logic [MAIN_W-1:0] swalFieldWide;
  logic              wordOk;

  assign mainField     = ratioWord[RATIO_W-1:SWAL_W];
  assign swalFieldWide = {{(MAIN_W-SWAL_W){1'b0}}, ratioWord[SWAL_W-1:0]};

  // R5: a word must reach the minimum, and its swallow count may not exceed
  // its main count, or the 17-clock periods would not fit in the cycle.
  assign wordOk     = (ratioWord >= MIN_WORD) && (swalFieldWide <= mainField);
  assign loadAccept = loadStrobe && wordOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioErr <= 1'b0;
    end else if (loadStrobe) begin
      ratioErr <= !wordOk;
    end
  end

endmodule

// File: rtl/swallowDivCtrl.sv
module swallowDivCtrl
  import swallowDivPkg::*;
#(
  parameter int SWAL_W  = 4,
  localparam int PRES_MOD = 1 << SWAL_W,
  localparam int PRES_W   = SWAL_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        swallowZero,
  input  logic        mainLast,
  output divStrobes_t strb
);

  localparam logic [PRES_W-1:0] TOP_SHORT = PRES_W'(PRES_MOD - 1);
  localparam logic [PRES_W-1:0] TOP_LONG  = PRES_W'(PRES_MOD);

  logic [PRES_W-1:0] presCnt;
  logic [PRES_W-1:0] presTop;

  // Long modulus while swallow periods remain, short one afterwards.
  assign presTop = swallowZero ? TOP_SHORT : TOP_LONG;

  always_comb begin
    strb.presWrap    = (presCnt == presTop);
    strb.cycleEnd    = strb.presWrap && mainLast;
    strb.swallowStep = strb.presWrap && !swallowZero && !mainLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (strb.presWrap) begin
      presCnt <= '0;
    end else begin
      presCnt <= presCnt + 1'b1;
    end
  end

  // R2: the prescaler never counts past the long modulus.
  a_r2_pres_bound: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= TOP_LONG);

  // R2: the long modulus is used only while swallow periods remain.
  a_r2_long_needs_swallow: assert property (@(posedge clk) disable iff (!rstN)
    (presCnt == TOP_LONG) |-> !swallowZero);

endmodule

// File: rtl/swallowDivDatapath.sv
module swallowDivDatapath
  import swallowDivPkg::*;
#(
  parameter int MAIN_W      = 13,
  parameter int SWAL_W      = 4,
  parameter int MIN_RATIO   = 240,
  parameter int RESET_RATIO = 240,
  localparam int RATIO_W    = MAIN_W + SWAL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobes_t        strb,
  input  logic               loadAccept,
  input  logic [RATIO_W-1:0] loadWord,
  output logic               swallowZero,
  output logic               mainLast,
  output logic               divPulse,
  output logic               divHalf
);

  localparam logic [RATIO_W-1:0] RESET_WORD = RATIO_W'(RESET_RATIO);
  localparam logic [RATIO_W-1:0] MIN_WORD   = RATIO_W'(MIN_RATIO);
  localparam logic [MAIN_W-1:0]  MAIN_ONE   = MAIN_W'(1);

  logic [RATIO_W-1:0] pendWord;
  logic               pendValid;
  logic [RATIO_W-1:0] activeWord;
  logic [RATIO_W-1:0] nextWord;
  logic [MAIN_W-1:0]  mainCnt;
  logic [SWAL_W-1:0]  swallowCnt;

  assign nextWord    = pendValid ? pendWord : activeWord;
  assign swallowZero = (swallowCnt == '0);
  assign mainLast    = (mainCnt == MAIN_ONE);

  // Parked word: a new acceptance overrides consumption on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord  <= RESET_WORD;
      pendValid <= 1'b0;
    end else begin
      if (strb.cycleEnd) pendValid <= 1'b0;
      if (loadAccept) begin
        pendWord  <= loadWord;
        pendValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeWord <= RESET_WORD;
      mainCnt    <= RESET_WORD[RATIO_W-1:SWAL_W];
      swallowCnt <= RESET_WORD[SWAL_W-1:0];
      divHalf    <= 1'b0;
      divPulse   <= 1'b0;
    end else begin
      divPulse <= strb.cycleEnd;
      if (strb.cycleEnd) begin
        activeWord <= nextWord;
        mainCnt    <= nextWord[RATIO_W-1:SWAL_W];
        swallowCnt <= nextWord[SWAL_W-1:0];
        divHalf    <= ~divHalf;
      end else if (strb.presWrap) begin
        mainCnt <= mainCnt - 1'b1;
        if (strb.swallowStep) swallowCnt <= swallowCnt - 1'b1;
      end
    end
  end

  // R3: the output pulse lasts one clock.
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R6: the half-rate output flips with every pulse and holds otherwise.
  a_r6_half_toggle: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> (divHalf != $past(divHalf)));
  a_r6_half_hold: assert property (@(posedge clk) disable iff (!rstN)
    !divPulse |-> $stable(divHalf));

  // R4: the governing ratio changes only on a cycle boundary.
  a_r4_active_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeWord) |-> $past(strb.cycleEnd));

  // R5: no refused word ever becomes the governing ratio.
  a_r5_active_min: assert property (@(posedge clk) disable iff (!rstN)
    activeWord >= MIN_WORD);

  // R2: swallow periods never outnumber the remaining main periods.
  a_r2_swallow_le_main: assert property (@(posedge clk) disable iff (!rstN)
    {{(MAIN_W-SWAL_W){1'b0}}, swallowCnt} <= mainCnt);

  // R2: the main count never reaches zero in a running cycle.
  a_r2_main_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt != '0);

endmodule

// File: rtl/swallowDivider.sv
module swallowDivider
  import swallowDivPkg::*;
#(
  parameter int MAIN_W      = 13,
  parameter int SWAL_W      = 4,
  parameter int MIN_RATIO   = 240,
  parameter int RESET_RATIO = 240,
  localparam int RATIO_W    = MAIN_W + SWAL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioWord,
  input  logic               loadStrobe,
  output logic               divPulse,
  output logic               divHalf,
  output logic               ratioErr
);

  divStrobes_t strb;
  logic        loadAccept;
  logic        swallowZero;
  logic        mainLast;

  swallowDivLoadCheck #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MIN_RATIO(MIN_RATIO)
  ) i_loadCheck (
    .clk(clk), .rstN(rstN), .ratioWord(ratioWord), .loadStrobe(loadStrobe),
    .loadAccept(loadAccept), .ratioErr(ratioErr)
  );

  swallowDivCtrl #(.SWAL_W(SWAL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .swallowZero(swallowZero), .mainLast(mainLast),
    .strb(strb)
  );

  swallowDivDatapath #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MIN_RATIO(MIN_RATIO),
    .RESET_RATIO(RESET_RATIO)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadAccept(loadAccept),
    .loadWord(ratioWord), .swallowZero(swallowZero), .mainLast(mainLast),
    .divPulse(divPulse), .divHalf(divHalf)
  );

endmodule

// File: tb/test_swallowDivider.sv
module test_swallowDivider;

  logic        clk = 1'b0;
  logic        rstN;
  logic [16:0] ratioWord;
  logic        loadStrobe;
  logic        divPulse;
  logic        divHalf;
  logic        ratioErr;

  int checks = 0;
  int fails  = 0;
  int curN;
  logic lastHalf;

  always #10 clk = ~clk;

  swallowDivider i_swallowDivider (
    .clk(clk), .rstN(rstN), .ratioWord(ratioWord), .loadStrobe(loadStrobe),
    .divPulse(divPulse), .divHalf(divHalf), .ratioErr(ratioErr)
  );

  // Vector: {expected refusal, ratio word}
  localparam int NVEC = 10;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 17'd241},
    {1'b1, 17'd239},
    {1'b0, 17'd255},
    {1'b0, 17'd256},
    {1'b1, 17'd0},
    {1'b0, 17'd271},
    {1'b0, 17'd240},
    {1'b1, 17'd200},
    {1'b0, 17'd1000},
    {1'b0, 17'd4095}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges until divPulse is seen; also checks width and divHalf.
  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!divPulse && n < 140000);
    check(n > 1, "R3 pulse wider than one clock", n, 2);
    check(divHalf != lastHalf, "R6 divHalf toggle at pulse", int'(divHalf), int'(!lastHalf));
    lastHalf = divHalf;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rstN = 1'b0;
    ratioWord = '0;
    loadStrobe = 1'b0;
    lastHalf = 1'b0;
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R1 reset divPulse", int'(divPulse), 0);
    check(divHalf == 1'b0, "R1 reset divHalf", int'(divHalf), 0);
    check(ratioErr == 1'b0, "R1 reset ratioErr", int'(ratioErr), 0);
    rstN = 1'b1;

    waitPulse(n);
    check(n == 240, "R1 first pulse after release", n, 240);
    waitPulse(n);
    check(n == 240, "R1 default period", n, 240);
    curN = 240;

    // Table walk: each load checks the running cycle (R4) and the next (R2/R5).
    for (int i = 0; i < NVEC; i++) begin
      int oldN;
      int newN;
      logic expErr;
      expErr = VEC[i][17];
      oldN = curN;
      newN = expErr ? curN : int'(VEC[i][16:0]);
      ratioWord = VEC[i][16:0];
      loadStrobe = 1'b1;
      @(negedge clk);
      loadStrobe = 1'b0;
      check(ratioErr == expErr, "R5 ratioErr after load", int'(ratioErr), int'(expErr));
      waitPulse(n);
      check(n + 1 == oldN, "R4 running cycle keeps old ratio", n + 1, oldN);
      waitPulse(n);
      check(n == newN, expErr ? "R5 refused word leaves period" : "R2 period equals 16M+A",
            n, newN);
      check(ratioErr == expErr, "R5 ratioErr holds until next load", int'(ratioErr), int'(expErr));
      curN = newN;
    end

    // R7: several loads in one cycle, last accepted one wins; refusal keeps it.
    ratioWord = 17'd300; loadStrobe = 1'b1;
    @(negedge clk);
    ratioWord = 17'd260;
    @(negedge clk);
    ratioWord = 17'd100;
    @(negedge clk);
    loadStrobe = 1'b0;
    check(ratioErr == 1'b1, "R5 ratioErr after refused load", int'(ratioErr), 1);
    waitPulse(n);
    check(n + 3 == curN, "R4 cycle with multiple loads", n + 3, curN);
    waitPulse(n);
    check(n == 260, "R7 last accepted word applied", n, 260);
    curN = 260;

    // R7: load sampled on the boundary edge waits for the following boundary.
    repeat (curN - 1) @(negedge clk);
    ratioWord = 17'd250;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    check(divPulse == 1'b1, "R3 pulse on boundary edge", int'(divPulse), 1);
    check(divHalf != lastHalf, "R6 divHalf toggle at pulse", int'(divHalf), int'(!lastHalf));
    lastHalf = divHalf;
    check(ratioErr == 1'b0, "R5 accepted load clears ratioErr", int'(ratioErr), 0);
    waitPulse(n);
    check(n == 260, "R7 boundary load not applied yet", n, 260);
    waitPulse(n);
    check(n == 250, "R7 boundary load applied next", n, 250);
    curN = 250;

    // R8: maximum ratio.
    ratioWord = 17'h1FFFF;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    check(ratioErr == 1'b0, "R8 max ratio accepted", int'(ratioErr), 0);
    waitPulse(n);
    check(n + 1 == curN, "R4 cycle before max ratio", n + 1, curN);
    waitPulse(n);
    check(n == 131071, "R8 max ratio period", n, 131071);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule